// File: doc/BRIEF.md
# Register Vector Configuration Lookup

This block holds the state that turns plain register operands into vector operands. Two bit maps, one for the integer register file and one for the floating-point file, flag each register as scalar or vector. A short list of configuration entries attaches an element count and a packed element size to chosen registers. Each entry names the register it applies to and the file that register sits in. Software loads all of this through one write port, with a select code and a data word.

Decode presents three operand lookups in every cycle: destination, first source and second source. Each lookup carries a register number and a file select. The block answers in the same cycle with a vector flag, an element count and a packed-width code. The vector flag needs only one bit-map read, so an operation can be classed as vector-vector, vector-scalar or scalar-scalar without any search.

The element count and the width come from a priority search over the entries, and the lowest-numbered matching entry wins. A register that no entry names reads as one element at the default width.

Top module: `vreg_cfg_lookup`

## Requirements
- R1: While reset is asserted, and after it is released, both bit maps read as all zero and every entry is invalid. Every lookup then returns flag 0, count 1 and the default width code. Reset takes effect at once, without waiting for a clock edge.
- R2: Write select 0 loads the 32-bit integer bit map from the write data. Bit n set means integer register n is a vector, and an integer lookup (file select 0) of register n returns that bit as its vector flag.
- R3: Write select 1 loads the floating-point bit map in the same way. It is read only by lookups with file select 1, and the two maps never affect each other.
- R4: Write select 2+k loads entry k. The data fields are: bits [4:0] register number, bit [5] file (0 integer, 1 float), bits [10:6] element count, bits [12:11] width code, bit [15] valid. A lookup whose register number and file both equal those of a valid entry returns that entry's count and width.
- R5: When more than one valid entry matches a lookup, entry 0 supplies the count and width, and entry 1 is ignored.
- R6: A lookup that matches no valid entry returns count 1 and the default width code. The width codes are 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64, and the default is the code for XLEN, which is 3 when XLEN is 64.
- R7: An entry matches only lookups whose file select equals its file bit. The same register number in the other file gets the R6 result.
- R8: An element count written as 0 reads back as 1, and a count above 16 reads back as 16.
- R9: All three lookup ports (rd at index 0, rs1 at index 1, rs2 at index 2) answer in the same cycle as their inputs and independently of each other. A write changes the lookup results only after the next rising clock edge.
- R10: An entry written with valid bit 0 takes part in no match.
- R11: Nothing changes when the write enable is low, or when the select code is 4 or higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside before release |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Write target: 0 integer map, 1 float map, 2+k entry k |
| cfg_wdata | input | 32 | Write data |
| lk_reg | input | 15 | Register numbers, 5 bits per port, rd lowest |
| lk_fp | input | 3 | File select per port (1 = floating point) |
| lk_vec | output | 3 | Vector flag per port |
| lk_len | output | 15 | Element count per port, 5 bits each |
| lk_bw | output | 6 | Width code per port, 2 bits each |

## Verification
The assertions assume that the write port is driven with known values whenever reset is inactive. They also assume that a lookup register number always lies inside the 32-entry file, which its 5-bit width guarantees. The stimulus changes write and lookup inputs only on falling clock edges and holds them stable across each rising edge. It releases reset only after the internal synchronizer has been given several cycles. Both files are used for the same register numbers, so that the file select is what separates a hit from a miss.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  localparam int unsigned SEL_INT_MAP    = 0;
  localparam int unsigned SEL_FP_MAP     = 1;
  localparam int unsigned SEL_ENTRY_BASE = 2;

  // entry write-data field positions
  localparam int unsigned EF_REG_LSB = 0;
  localparam int unsigned EF_BANK    = 5;
  localparam int unsigned EF_LEN_LSB = 6;
  localparam int unsigned EF_BW_LSB  = 11;
  localparam int unsigned EF_VALID   = 15;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2,
    BW_64 = 2'd3
  } vcfg_bw_e;

  function automatic logic [1:0] bw_code_for(input int unsigned width);
    int unsigned lg;
    lg = $clog2(width);
    if (lg < 3) lg = 3;
    if (lg > 6) lg = 6;
    return 2'(lg - 3);
  endfunction

endpackage

// File: rtl/vcfg_rst_sync.sv
module vcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vcfg_bitmap_bank.sv
module vcfg_bitmap_bank #(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_int,
  input  logic                we_fp,
  input  logic [NUM_REGS-1:0] wdata,
  output logic [NUM_REGS-1:0] int_map,
  output logic [NUM_REGS-1:0] fp_map
);

  logic [NUM_REGS-1:0] int_map_d;
  logic [NUM_REGS-1:0] fp_map_d;

  always_comb begin
    int_map_d = int_map;
    fp_map_d  = fp_map;
    if (we_int) int_map_d = wdata;
    if (we_fp)  fp_map_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_map <= '0;
      fp_map  <= '0;
    end else begin
      int_map <= int_map_d;
      fp_map  <= fp_map_d;
    end
  end

  // R2: an integer map write is visible after the next edge
  a_r2_int_map_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_int |=> int_map == $past(wdata));

  // R3: a float map write is visible after the next edge
  a_r3_fp_map_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_fp |=> fp_map == $past(wdata));

  // R11: without a write strobe the maps hold
  a_r11_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_int && !we_fp) |=> ($stable(int_map) && $stable(fp_map)));

endmodule

// File: rtl/vcfg_entry_file.sv
module vcfg_entry_file #(
  parameter int unsigned NUM_ENTRIES = 2,
  parameter int unsigned REG_IDX_W   = 5,
  parameter int unsigned LEN_W       = 5,
  parameter int unsigned MAX_LEN     = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_ENTRIES-1:0]           ent_we,
  input  logic                             w_valid,
  input  logic                             w_bank,
  input  logic [REG_IDX_W-1:0]             w_reg,
  input  logic [LEN_W-1:0]                 w_len,
  input  logic [1:0]                       w_bw,
  output logic [NUM_ENTRIES-1:0]           ent_valid,
  output logic [NUM_ENTRIES-1:0]           ent_bank,
  output logic [NUM_ENTRIES*REG_IDX_W-1:0] ent_reg,
  output logic [NUM_ENTRIES*LEN_W-1:0]     ent_len,
  output logic [NUM_ENTRIES*2-1:0]         ent_bw
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] len_norm;

  // element count normalised once on the way in
  always_comb begin
    if (w_len == '0)          len_norm = LEN_ONE;
    else if (w_len > LEN_CAP) len_norm = LEN_CAP;
    else                      len_norm = w_len;
  end

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
    logic                 valid_d, bank_d;
    logic [REG_IDX_W-1:0] reg_d;
    logic [LEN_W-1:0]     len_d;
    logic [1:0]           bw_d;

    always_comb begin
      valid_d = ent_valid[k];
      bank_d  = ent_bank[k];
      reg_d   = ent_reg[k*REG_IDX_W +: REG_IDX_W];
      len_d   = ent_len[k*LEN_W +: LEN_W];
      bw_d    = ent_bw[k*2 +: 2];
      if (ent_we[k]) begin
        valid_d = w_valid;
        bank_d  = w_bank;
        reg_d   = w_reg;
        len_d   = len_norm;
        bw_d    = w_bw;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[k]                        <= 1'b0;
        ent_bank[k]                         <= 1'b0;
        ent_reg[k*REG_IDX_W +: REG_IDX_W]   <= '0;
        ent_len[k*LEN_W +: LEN_W]           <= LEN_ONE;
        ent_bw[k*2 +: 2]                    <= '0;
      end else begin
        ent_valid[k]                        <= valid_d;
        ent_bank[k]                         <= bank_d;
        ent_reg[k*REG_IDX_W +: REG_IDX_W]   <= reg_d;
        ent_len[k*LEN_W +: LEN_W]           <= len_d;
        ent_bw[k*2 +: 2]                    <= bw_d;
      end
    end

    // R8: a zero count written to this entry reads as one
    a_r8_len_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we[k] && w_len == '0) |=> ent_len[k*LEN_W +: LEN_W] == LEN_ONE);

    // R8: an oversize count written to this entry reads as the cap
    a_r8_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we[k] && w_len > LEN_CAP) |=> ent_len[k*LEN_W +: LEN_W] == LEN_CAP);
  end

endmodule

// File: rtl/vcfg_port_resolve.sv
module vcfg_port_resolve #(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned NUM_ENTRIES = 2,
  parameter int unsigned REG_IDX_W   = 5,
  parameter int unsigned LEN_W       = 5,
  parameter logic [1:0]  DEF_BW      = 2'd3
) (
  input  logic [REG_IDX_W-1:0]             q_reg,
  input  logic                             q_fp,
  input  logic [NUM_REGS-1:0]              int_map,
  input  logic [NUM_REGS-1:0]              fp_map,
  input  logic [NUM_ENTRIES-1:0]           ent_valid,
  input  logic [NUM_ENTRIES-1:0]           ent_bank,
  input  logic [NUM_ENTRIES*REG_IDX_W-1:0] ent_reg,
  input  logic [NUM_ENTRIES*LEN_W-1:0]     ent_len,
  input  logic [NUM_ENTRIES*2-1:0]         ent_bw,
  output logic                             r_vec,
  output logic [LEN_W-1:0]                 r_len,
  output logic [1:0]                       r_bw
);

  logic [NUM_ENTRIES-1:0] hit;

  // single bit test per operand
  always_comb begin
    r_vec = q_fp ? fp_map[q_reg] : int_map[q_reg];
  end

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_cmp
    assign hit[k] = ent_valid[k] && (ent_bank[k] == q_fp) &&
                    (ent_reg[k*REG_IDX_W +: REG_IDX_W] == q_reg);
  end

  // walk from the last entry down so the lowest index overrides
  always_comb begin
    r_len = LEN_W'(1);
    r_bw  = DEF_BW;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        r_len = ent_len[k*LEN_W +: LEN_W];
        r_bw  = ent_bw[k*2 +: 2];
      end
    end
  end

endmodule

// File: rtl/vreg_cfg_lookup.sv
module vreg_cfg_lookup #(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned NUM_ENTRIES = 2,
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned LEN_W       = 5,
  parameter int unsigned MAX_LEN     = 16,
  parameter int unsigned XLEN        = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [2:0]                     cfg_sel,
  input  logic [31:0]                    cfg_wdata,
  input  logic [14:0]                    lk_reg,
  input  logic [2:0]                     lk_fp,
  output logic [2:0]                     lk_vec,
  output logic [14:0]                    lk_len,
  output logic [5:0]                     lk_bw
);
  import vcfg_pkg::*;

  localparam int unsigned REG_IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned CFG_SEL_W  = 3;
  localparam logic [1:0]  DEF_BW     = bw_code_for(XLEN);

  logic rst_sync_n;

  vcfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // write decode
  logic                   we_int, we_fp;
  logic [NUM_ENTRIES-1:0] ent_we;

  always_comb begin
    we_int = cfg_we && (cfg_sel == CFG_SEL_W'(SEL_INT_MAP));
    we_fp  = cfg_we && (cfg_sel == CFG_SEL_W'(SEL_FP_MAP));
  end

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_dec
    assign ent_we[k] = cfg_we && (cfg_sel == CFG_SEL_W'(SEL_ENTRY_BASE + k));
  end

  logic [NUM_REGS-1:0] int_map, fp_map;

  vcfg_bitmap_bank #(.NUM_REGS(NUM_REGS)) u_maps (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_int  (we_int),
    .we_fp   (we_fp),
    .wdata   (cfg_wdata[NUM_REGS-1:0]),
    .int_map (int_map),
    .fp_map  (fp_map)
  );

  logic [NUM_ENTRIES-1:0]           ent_valid, ent_bank;
  logic [NUM_ENTRIES*REG_IDX_W-1:0] ent_reg;
  logic [NUM_ENTRIES*LEN_W-1:0]     ent_len;
  logic [NUM_ENTRIES*2-1:0]         ent_bw;

  vcfg_entry_file #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .REG_IDX_W   (REG_IDX_W),
    .LEN_W       (LEN_W),
    .MAX_LEN     (MAX_LEN)
  ) u_entries (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ent_we    (ent_we),
    .w_valid   (cfg_wdata[EF_VALID]),
    .w_bank    (cfg_wdata[EF_BANK]),
    .w_reg     (cfg_wdata[EF_REG_LSB +: REG_IDX_W]),
    .w_len     (cfg_wdata[EF_LEN_LSB +: LEN_W]),
    .w_bw      (cfg_wdata[EF_BW_LSB +: 2]),
    .ent_valid (ent_valid),
    .ent_bank  (ent_bank),
    .ent_reg   (ent_reg),
    .ent_len   (ent_len),
    .ent_bw    (ent_bw)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    vcfg_port_resolve #(
      .NUM_REGS    (NUM_REGS),
      .NUM_ENTRIES (NUM_ENTRIES),
      .REG_IDX_W   (REG_IDX_W),
      .LEN_W       (LEN_W),
      .DEF_BW      (DEF_BW)
    ) u_res (
      .q_reg     (lk_reg[p*REG_IDX_W +: REG_IDX_W]),
      .q_fp      (lk_fp[p]),
      .int_map   (int_map),
      .fp_map    (fp_map),
      .ent_valid (ent_valid),
      .ent_bank  (ent_bank),
      .ent_reg   (ent_reg),
      .ent_len   (ent_len),
      .ent_bw    (ent_bw),
      .r_vec     (lk_vec[p]),
      .r_len     (lk_len[p*LEN_W +: LEN_W]),
      .r_bw      (lk_bw[p*2 +: 2])
    );

    // R5: a hit on entry 0 always decides the port result
    a_r5_first_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ent_valid[0] && ent_bank[0] == lk_fp[p] &&
       ent_reg[0 +: REG_IDX_W] == lk_reg[p*REG_IDX_W +: REG_IDX_W])
      |-> (lk_len[p*LEN_W +: LEN_W] == ent_len[0 +: LEN_W] &&
           lk_bw[p*2 +: 2] == ent_bw[0 +: 2]));

    // R6: with no valid entry every port reads scalar at the default width
    a_r6_scalar_fallback: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ent_valid == '0) |-> (lk_len[p*LEN_W +: LEN_W] == LEN_W'(1) &&
                             lk_bw[p*2 +: 2] == DEF_BW));
  end

endmodule

// File: tb/vreg_cfg_lookup_bench.sv
module vreg_cfg_lookup_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [14:0] lk_reg;
  logic [2:0]  lk_fp;
  logic [2:0]  lk_vec;
  logic [14:0] lk_len;
  logic [5:0]  lk_bw;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vreg_cfg_lookup u_vreg_cfg_lookup (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
    .cfg_wdata (cfg_wdata), .lk_reg (lk_reg), .lk_fp (lk_fp),
    .lk_vec (lk_vec), .lk_len (lk_len), .lk_bw (lk_bw)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic       fp;
    logic [4:0] rn;
    logic       ev;
    logic [4:0] el;
    logic [1:0] eb;
  } lk_vec_t;

  // after setup: int map regs 4..7, fp map regs 1 and 16,
  // entry0 = int r4 len 8 bw16, entry1 = fp r1 len 16 bw32
  localparam int NV = 8;
  localparam lk_vec_t TBL [NV] = '{
    '{1'b0, 5'd4,  1'b1, 5'd8,  2'd1},
    '{1'b0, 5'd5,  1'b1, 5'd1,  2'd3},
    '{1'b1, 5'd4,  1'b0, 5'd1,  2'd3},
    '{1'b1, 5'd1,  1'b1, 5'd16, 2'd2},
    '{1'b0, 5'd1,  1'b0, 5'd1,  2'd3},
    '{1'b1, 5'd16, 1'b1, 5'd1,  2'd3},
    '{1'b0, 5'd0,  1'b0, 5'd1,  2'd3},
    '{1'b0, 5'd31, 1'b0, 5'd1,  2'd3}
  };

  function automatic logic [31:0] mk_ent(input logic v, input logic bank,
      input logic [4:0] rn, input logic [4:0] len, input logic [1:0] bw);
    return {16'h0, v, 2'b00, bw, len, bank, rn};
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_port(input int p, input logic fp, input logic [4:0] rn);
    lk_reg[p*5 +: 5] = rn;
    lk_fp[p] = fp;
  endtask

  task automatic chk_port(input string tag, input int p, input logic ev,
      input logic [4:0] el, input logic [1:0] eb);
    checks++;
    if (lk_vec[p] !== ev || lk_len[p*5 +: 5] !== el || lk_bw[p*2 +: 2] !== eb) begin
      fails++;
      $display("FAIL %s port%0d: got vec=%0b len=%0d bw=%0d exp vec=%0b len=%0d bw=%0d",
               tag, p, lk_vec[p], lk_len[p*5 +: 5], lk_bw[p*2 +: 2], ev, el, eb);
    end
  endtask

  task automatic look(input string tag, input int p, input logic fp, input logic [4:0] rn,
      input logic ev, input logic [4:0] el, input logic [1:0] eb);
    @(negedge clk);
    lk_reg = '0; lk_fp = '0;
    set_port(p, fp, rn);
    #1;
    chk_port(tag, p, ev, el, eb);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    lk_reg = '0; lk_fp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state is scalar everywhere
    look("R1 int r4", 0, 1'b0, 5'd4, 1'b0, 5'd1, 2'd3);
    look("R1 fp r1",  2, 1'b1, 5'd1, 1'b0, 5'd1, 2'd3);

    cfg_write(3'd0, 32'h0000_00F0);
    cfg_write(3'd1, 32'h0001_0002);
    cfg_write(3'd2, mk_ent(1'b1, 1'b0, 5'd4, 5'd8, 2'd1));
    cfg_write(3'd3, mk_ent(1'b1, 1'b1, 5'd1, 5'd16, 2'd2));

    // R2 R3 R4 R6 R7: table walk, rotating across ports
    for (int i = 0; i < NV; i++) begin
      look("R2/R3/R4/R6/R7 table", i % 3, TBL[i].fp, TBL[i].rn, TBL[i].ev, TBL[i].el, TBL[i].eb);
    end

    // R9: all three ports resolve together in one cycle
    @(negedge clk);
    set_port(0, 1'b0, 5'd4); set_port(1, 1'b1, 5'd1); set_port(2, 1'b1, 5'd4);
    #1;
    chk_port("R9 rd",  0, 1'b1, 5'd8,  2'd1);
    chk_port("R9 rs1", 1, 1'b1, 5'd16, 2'd2);
    chk_port("R9 rs2", 2, 1'b0, 5'd1,  2'd3);

    // R5: entry1 also names int r4, entry0 still wins
    cfg_write(3'd3, mk_ent(1'b1, 1'b0, 5'd4, 5'd3, 2'd0));
    look("R5 entry0 wins", 1, 1'b0, 5'd4, 1'b1, 5'd8, 2'd1);

    // R10: invalidate entry0, entry1 now visible
    cfg_write(3'd2, mk_ent(1'b0, 1'b0, 5'd4, 5'd8, 2'd1));
    look("R10 invalid entry0", 1, 1'b0, 5'd4, 1'b1, 5'd3, 2'd0);

    // R8: count 0 reads 1, count 20 reads 16
    cfg_write(3'd2, mk_ent(1'b1, 1'b0, 5'd9, 5'd0, 2'd2));
    look("R8 zero count", 0, 1'b0, 5'd9, 1'b0, 5'd1, 2'd2);
    cfg_write(3'd2, mk_ent(1'b1, 1'b0, 5'd9, 5'd20, 2'd2));
    look("R8 capped count", 0, 1'b0, 5'd9, 1'b0, 5'd16, 2'd2);

    // R9: write not visible before the edge, visible after it
    @(negedge clk);
    lk_reg = '0; lk_fp = '0; set_port(2, 1'b0, 5'd12);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0000_1000;
    #1;
    chk_port("R9 before edge", 2, 1'b0, 5'd1, 2'd3);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk_port("R9 after edge", 2, 1'b1, 5'd1, 2'd3);

    // R11: enable low, then an unused select code
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_sel = 3'd2; cfg_wdata = mk_ent(1'b1, 1'b0, 5'd12, 5'd5, 2'd0);
    @(negedge clk);
    cfg_write(3'd5, 32'hFFFF_FFFF);
    look("R11 we low map", 2, 1'b0, 5'd12, 1'b1, 5'd1, 2'd3);
    look("R11 bad sel fp", 1, 1'b1, 5'd20, 1'b0, 5'd1, 2'd3);
    look("R11 entry kept", 0, 1'b0, 5'd9, 1'b0, 5'd16, 2'd2);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    lk_reg = '0; lk_fp = '0; set_port(0, 1'b0, 5'd9);
    rst_n = 1'b0;
    #1;
    chk_port("R1 async clear", 0, 1'b0, 5'd1, 2'd3);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    look("R1 after release", 1, 1'b0, 5'd12, 1'b0, 5'd1, 2'd3);

    done = 1;
    finish_run();
  end

endmodule